// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table Controller

This block keeps the per-vector message table and the pending-bit array of one PCI function that signals interrupts by writing messages to memory. Software reaches both through a 32-bit register port that decodes one 4 KB page. The table sits in the lower half of the page and the pending bits sit in the upper half. A control byte carries the function-wide enable and mask-all bits. The configuration-space logic forwards writes to that byte and reads its current value back.

Each vector has an interrupt request input. A request to an active, unmasked vector becomes one message on a valid/ready output that carries the 64-bit address and 32-bit data stored in that vector's entry. A request to a masked vector sets its pending bit instead. When a vector leaves the masked state with its pending bit set, the block clears the bit and sends the message it held back. Device logic declares which vectors it uses through reference counts. A vector whose count is zero drops its requests, and the release that brings a count to zero discards any pending message for that vector.

Top module: `msix_vector_ctrl`

## Requirements
- R1: The register port decodes only address bits [11:2]. Bits above 11 and bits [1:0] are ignored. An entry for vector v occupies byte offset v*16: word 0 is address low, word 1 is address high, word 2 is data, and word 3 is vector control, whose bit 0 is the mask and whose other bits read 0. Read data appears on `reg_rdata` one cycle after `reg_rd`.
- R2: The pending array starts at offset 0x800. Bit v of the word at 0x800 is the pending bit of vector v. Every other word in the upper half, and every entry word of a vector at or beyond NUM_VEC, reads 0.
- R3: A write whose vector index (offset / 16) is NUM_VEC or higher is ignored. This covers every address in the pending half.
- R4: After reset every entry reads 0 except that each mask bit reads 1. The control byte, the pending bits, the use counts and `msg_valid` are all 0.
- R5: `ctl_wr` loads bit 7 (enable) and bit 6 (mask-all) of `ctl_wdata`, and `ctl_state` returns them in the same positions. The function mask is active when enable is 0 or mask-all is 1. `intx_clr` pulses for one cycle on the cycle after a control write with bit 7 set.
- R6: A request to a vector whose use count is zero produces no message and sets no pending bit.
- R7: A request to a used vector that is masked, by its own mask bit or by the function mask, sets its pending bit and produces no message.
- R8: A request to a used, unmasked vector produces a message with address {address high, address low} and the entry's data. `msg_valid` rises on the second clock edge after the request.
- R9: When a vector goes from masked to unmasked with its pending bit set, the block clears the bit and sends the vector's message. Unmasking a vector that has nothing pending sends nothing.
- R10: Messages waiting together are sent one per accepted handshake, lowest vector first. While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold their values.
- R11: A use request raises the count of the addressed vector, saturating at 2^CNT_W-1. A release lowers a nonzero count and has no effect on a zero count. A release that brings the count to zero clears that vector's pending bit.
- R12: `tbl_size` reports NUM_VEC-1.
- R13: Further requests to a vector that is already pending, or already queued for sending, merge into the single message that is already waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| ctl_wr | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Control byte: bit 7 enable, bit 6 mask-all |
| ctl_state | output | 8 | Current control byte |
| intx_clr | output | 1 | Pulse that deasserts the legacy interrupt line |
| tbl_size | output | 11 | Vector count minus one |
| irq | input | NUM_VEC | Per-vector request pulses |
| use_req | input | 1 | Raise the use count of `use_vec` |
| rel_req | input | 1 | Lower the use count of `use_vec` |
| use_vec | input | VW | Vector addressed by a use or release request |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | The downstream side accepts the message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The bench builds the block with NUM_VEC=6 and CNT_W=2. Six vectors leave unused entry slots 6 and 7 inside the same 3-bit index, so the ignored writes and the zero reads above the vector count can be reached. A 2-bit count saturates after three use requests, so saturation and the no-wrap release at zero are both reachable. At this size the bench can sweep every table word after reset and again after loading, and it can hold several vectors pending at once to check the drain order under back-pressure.

// File: rtl/msix_pkg.sv
package msix_pkg;
  localparam int MAX_VEC = 32;
  localparam int CTL_EN_BIT = 7;
  localparam int CTL_MASKALL_BIT = 6;

  typedef enum logic [1:0] {
    W_ADDR_LO = 2'd0,
    W_ADDR_HI = 2'd1,
    W_DATA    = 2'd2,
    W_CTRL    = 2'd3
  } ent_word_e;
endpackage

// File: rtl/msix_table.sv
module msix_table #(
  parameter int NUM_VEC = 32,
  localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [VW-1:0]        wr_vec,
  input  msix_pkg::ent_word_e  wr_word,
  input  logic [31:0]          wr_data,
  input  logic [VW-1:0]        rd_vec,
  input  msix_pkg::ent_word_e  rd_word,
  output logic [31:0]          rd_data,
  input  logic [VW-1:0]        sel_vec,
  output logic [63:0]          sel_addr,
  output logic [31:0]          sel_data,
  output logic [NUM_VEC-1:0]   ent_mask
);
  import msix_pkg::*;

  logic [31:0]        lo_q  [NUM_VEC];
  logic [31:0]        hi_q  [NUM_VEC];
  logic [31:0]        dat_q [NUM_VEC];
  logic [NUM_VEC-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_VEC; i++) begin
        lo_q[i]  <= '0;
        hi_q[i]  <= '0;
        dat_q[i] <= '0;
      end
      mask_q <= '1;
    end else if (wr_en) begin
      case (wr_word)
        W_ADDR_LO: lo_q[wr_vec]   <= wr_data;
        W_ADDR_HI: hi_q[wr_vec]   <= wr_data;
        W_DATA:    dat_q[wr_vec]  <= wr_data;
        default:   mask_q[wr_vec] <= wr_data[0];
      endcase
    end
  end

  always_comb begin
    case (rd_word)
      W_ADDR_LO: rd_data = lo_q[rd_vec];
      W_ADDR_HI: rd_data = hi_q[rd_vec];
      W_DATA:    rd_data = dat_q[rd_vec];
      default:   rd_data = {31'd0, mask_q[rd_vec]};
    endcase
  end

  assign sel_addr = {hi_q[sel_vec], lo_q[sel_vec]};
  assign sel_data = dat_q[sel_vec];
  assign ent_mask = mask_q;

  // R4: every entry leaves reset masked
  p_reset_masks_r4: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&ent_mask));
endmodule

// File: rtl/msix_usecnt.sv
module msix_usecnt #(
  parameter int NUM_VEC = 32,
  parameter int CNT_W = 8,
  localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               use_req,
  input  logic               rel_req,
  input  logic [VW-1:0]      sel,
  output logic [NUM_VEC-1:0] in_use,
  output logic [NUM_VEC-1:0] hit_zero
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    logic hit, inc, dec;

    assign hit = (sel == VW'(v));
    assign inc = hit && use_req && !rel_req;
    assign dec = hit && rel_req && !use_req;

    always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else if (inc && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      else if (dec && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign in_use[v]   = (cnt_q != '0);
    assign hit_zero[v] = dec && (cnt_q == CNT_W'(1));

    // R11: release at zero keeps zero, use at the top keeps the top
    p_no_wrap_r11: assert property (@(posedge clk) disable iff (rst)
      (dec && cnt_q == '0) |=> (cnt_q == '0));
    p_saturate_r11: assert property (@(posedge clk) disable iff (rst)
      (inc && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
  end
endmodule

// File: rtl/msix_sched.sv
module msix_sched #(
  parameter int NUM_VEC = 32,
  localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_VEC-1:0] irq,
  input  logic [NUM_VEC-1:0] masked,
  input  logic [NUM_VEC-1:0] in_use,
  input  logic [NUM_VEC-1:0] drop_pend,
  input  logic [63:0]        tbl_addr,
  input  logic [31:0]        tbl_data,
  output logic [VW-1:0]      sel_vec,
  output logic [NUM_VEC-1:0] pending,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data
);
  logic [NUM_VEC-1:0] pend_q, fire_q, prev_mask_q;
  logic [NUM_VEC-1:0] replay, direct, held, defer, pick_oh;
  logic slot_free, any_fire, go;

  assign slot_free = !msg_valid || msg_ready;
  assign replay    = prev_mask_q & ~masked & pend_q;
  assign direct    = irq & in_use & ~masked;
  assign held      = irq & in_use & masked;

  // lowest-numbered queued vector wins
  always_comb begin
    sel_vec  = '0;
    any_fire = 1'b0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (fire_q[i]) begin
        sel_vec  = VW'(i);
        any_fire = 1'b1;
      end
    end
  end

  assign pick_oh = (any_fire && slot_free) ? (NUM_VEC'(1) << sel_vec) : '0;
  assign go      = any_fire && slot_free && in_use[sel_vec] && !masked[sel_vec];
  assign defer   = pick_oh & masked & in_use;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= '0;
      fire_q      <= '0;
      prev_mask_q <= '1;
      msg_valid   <= 1'b0;
      msg_addr    <= '0;
      msg_data    <= '0;
    end else begin
      prev_mask_q <= masked;
      fire_q      <= (fire_q & ~pick_oh) | direct | replay;
      pend_q      <= ((pend_q & ~replay) | held | defer) & ~drop_pend;
      if (slot_free) begin
        msg_valid <= go;
        if (go) begin
          msg_addr <= tbl_addr;
          msg_data <= tbl_data;
        end
      end
    end
  end

  assign pending = pend_q;

  // R10: an offered message is held until accepted
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_chk
    // R7: a pending bit appears only for a vector that was masked
    p_pend_masked_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(pend_q[v]) |-> $past(masked[v]));
    // R11: no pending bit survives on a vector with zero use count
    p_pend_used_r11: assert property (@(posedge clk) disable iff (rst)
      pend_q[v] |-> in_use[v]);
    // R9: a replayed vector's pending bit is cleared
    p_replay_clear_r9: assert property (@(posedge clk) disable iff (rst)
      replay[v] |=> !pend_q[v]);
  end
endmodule

// File: rtl/msix_vector_ctrl.sv
module msix_vector_ctrl #(
  parameter int NUM_VEC = 32,
  parameter int CNT_W = 8,
  parameter int ADDR_W = 16,
  localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               ctl_wr,
  input  logic [7:0]         ctl_wdata,
  output logic [7:0]         ctl_state,
  output logic               intx_clr,
  output logic [10:0]        tbl_size,
  input  logic [NUM_VEC-1:0] irq,
  input  logic               use_req,
  input  logic               rel_req,
  input  logic [VW-1:0]      use_vec,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data
);
  import msix_pkg::*;

  // word index inside the page; address is taken modulo 4 KB, word aligned
  logic [9:0]  widx;
  logic        in_pba, ent_ok;
  logic [6:0]  ent_idx;
  ent_word_e   word_sel;
  logic        unused_addr;

  assign widx        = reg_addr[11:2];
  assign in_pba      = widx[9];
  assign ent_idx     = widx[8:2];
  assign word_sel    = ent_word_e'(widx[1:0]);
  assign ent_ok      = !in_pba && (ent_idx < 7'(NUM_VEC));
  assign unused_addr = ^{reg_addr[ADDR_W-1:12], reg_addr[1:0], ctl_wdata[5:0]};

  logic               en_q, ma_q, intx_q, fmask;
  logic [NUM_VEC-1:0] ent_mask, masked, in_use, hit_zero, pending;
  logic [31:0]        tbl_rd, pba_word;
  logic [VW-1:0]      sel_vec;
  logic [63:0]        sel_addr;
  logic [31:0]        sel_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      ma_q   <= 1'b0;
      intx_q <= 1'b0;
    end else begin
      intx_q <= ctl_wr && ctl_wdata[CTL_EN_BIT];
      if (ctl_wr) begin
        en_q <= ctl_wdata[CTL_EN_BIT];
        ma_q <= ctl_wdata[CTL_MASKALL_BIT];
      end
    end
  end

  assign fmask     = !en_q || ma_q;
  assign masked    = ent_mask | {NUM_VEC{fmask}};
  assign ctl_state = {en_q, ma_q, 6'd0};
  assign intx_clr  = intx_q;
  assign tbl_size  = 11'(NUM_VEC - 1);

  msix_table #(.NUM_VEC(NUM_VEC)) u_table (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr && ent_ok),
    .wr_vec   (ent_idx[VW-1:0]),
    .wr_word  (word_sel),
    .wr_data  (reg_wdata),
    .rd_vec   (ent_idx[VW-1:0]),
    .rd_word  (word_sel),
    .rd_data  (tbl_rd),
    .sel_vec  (sel_vec),
    .sel_addr (sel_addr),
    .sel_data (sel_data),
    .ent_mask (ent_mask)
  );

  msix_usecnt #(.NUM_VEC(NUM_VEC), .CNT_W(CNT_W)) u_usecnt (
    .clk      (clk),
    .rst      (rst),
    .use_req  (use_req),
    .rel_req  (rel_req),
    .sel      (use_vec),
    .in_use   (in_use),
    .hit_zero (hit_zero)
  );

  msix_sched #(.NUM_VEC(NUM_VEC)) u_sched (
    .clk       (clk),
    .rst       (rst),
    .irq       (irq),
    .masked    (masked),
    .in_use    (in_use),
    .drop_pend (hit_zero),
    .tbl_addr  (sel_addr),
    .tbl_data  (sel_data),
    .sel_vec   (sel_vec),
    .pending   (pending),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data)
  );

  assign pba_word = (widx[8:0] == 9'd0) ? 32'(pending) : 32'd0;

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= in_pba ? pba_word : (ent_ok ? tbl_rd : 32'd0);
  end

  // R5: the legacy-line pulse follows a control write that sets enable
  p_intx_r5: assert property (@(posedge clk) disable iff (rst)
    intx_clr |-> ($past(ctl_wr) && $past(ctl_wdata[CTL_EN_BIT])));
  // R5: no new message starts while the function mask is active
  p_fmask_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> $past(!fmask));
endmodule

// File: tb/sim_msix_vector_ctrl.sv
module sim_msix_vector_ctrl;
  localparam int NV = 6;
  localparam int CW = 2;
  localparam int AW = 16;
  localparam int VW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          reg_wr = 0, reg_rd = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0, reg_rdata;
  logic          ctl_wr = 0;
  logic [7:0]    ctl_wdata = '0, ctl_state;
  logic          intx_clr;
  logic [10:0]   tbl_size;
  logic [NV-1:0] irq = '0;
  logic          use_req = 0, rel_req = 0;
  logic [VW-1:0] use_vec = '0;
  logic          msg_valid, msg_ready = 1'b1;
  logic [63:0]   msg_addr;
  logic [31:0]   msg_data;

  int checks = 0;
  int errors = 0;

  msix_vector_ctrl #(.NUM_VEC(NV), .CNT_W(CW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_state(ctl_state), .intx_clr(intx_clr), .tbl_size(tbl_size), .irq(irq),
    .use_req(use_req), .rel_req(rel_req), .use_vec(use_vec), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data));

  function automatic logic [31:0] exp_word(int v, int w);
    case (w)
      0: return 32'h1000_0000 + 32'(v * 16);
      1: return 32'hA000_0000 | 32'(v);
      2: return 32'hD000_0000 + 32'(v);
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    tick();
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic ctl(input logic [7:0] b);
    ctl_wr = 1; ctl_wdata = b;
    tick();
    ctl_wr = 0;
  endtask

  task automatic pulse(input int v);
    irq = NV'(1) << v;
    tick();
    irq = '0;
  endtask

  task automatic cnt(input int v, input bit up);
    use_vec = VW'(v);
    if (up) use_req = 1; else rel_req = 1;
    tick();
    use_req = 0; rel_req = 0;
  endtask

  task automatic expect_msg(input string req, input int v);
    int found = 0;
    for (int i = 0; i < 12; i++) begin
      if (msg_valid) begin found = 1; break; end
      tick();
    end
    chk(req, 64'(found), 64'd1);
    chk(req, msg_addr, {exp_word(v, 1), exp_word(v, 0)});
    chk(req, 64'(msg_data), 64'(exp_word(v, 2)));
    tick();
  endtask

  task automatic expect_none(input string req, input int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      if (msg_valid) seen = 1;
      tick();
    end
    chk(req, 64'(seen), 64'd0);
  endtask

  task automatic expect_pend(input string req, input logic [31:0] e);
    logic [31:0] d;
    rd(16'h0800, d);
    chk(req, 64'(d), 64'(e));
  endtask

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] a0;
    repeat (3) tick();
    rst = 0;
    tick();

    // R4 reset state, R12 size field
    chk("R4", 64'(msg_valid), 64'd0);
    chk("R4", 64'(ctl_state), 64'd0);
    chk("R4", 64'(intx_clr), 64'd0);
    chk("R12", 64'(tbl_size), 64'(NV - 1));
    for (int v = 0; v < NV; v++)
      for (int w = 0; w < 4; w++) begin
        rd(AW'(v * 16 + w * 4), d);
        chk("R4", 64'(d), (w == 3) ? 64'd1 : 64'd0);
      end
    expect_pend("R4", 32'd0);

    // R1 load every entry; data words use high and low address bits that must be ignored
    for (int v = 0; v < NV; v++) begin
      wr(AW'(v * 16), exp_word(v, 0));
      wr(AW'(v * 16 + 4) | 16'h5000, exp_word(v, 1));
      wr(AW'(v * 16 + 8) | 16'h3003, exp_word(v, 2));
      wr(AW'(v * 16 + 12), 32'hFFFF_FFFE);
    end
    for (int v = 0; v < NV; v++)
      for (int w = 0; w < 4; w++) begin
        rd(AW'(v * 16 + w * 4), d);
        chk("R1", 64'(d), 64'(exp_word(v, w)));
      end

    // R3 writes beyond the vector count and into the pending half are ignored
    for (int o = NV * 16; o < 128; o += 4) wr(AW'(o), 32'hFFFF_FFFF);
    wr(16'h0800, 32'hFFFF_FFFF);
    wr(16'h080C, 32'hFFFF_FFFF);
    for (int o = NV * 16; o < 128; o += 4) begin
      rd(AW'(o), d);
      chk("R2", 64'(d), 64'd0);
    end
    rd(16'h0000, d); chk("R3", 64'(d), 64'(exp_word(0, 0)));
    rd(16'h000C, d); chk("R3", 64'(d), 64'd0);
    expect_pend("R3", 32'd0);
    rd(16'h0804, d); chk("R2", 64'(d), 64'd0);

    // R5 enable, legacy-line pulse
    ctl(8'h80);
    chk("R5", 64'(intx_clr), 64'd1);
    chk("R5", 64'(ctl_state), 64'h80);
    tick();
    chk("R5", 64'(intx_clr), 64'd0);

    // R6 request on unused vector
    pulse(0);
    expect_none("R6", 6);
    expect_pend("R6", 32'd0);

    // R8 direct sends, with the exact cycle for vector 0
    for (int v = 0; v < NV; v++) cnt(v, 1);
    pulse(0);
    chk("R8", 64'(msg_valid), 64'd0);
    tick();
    chk("R8", 64'(msg_valid), 64'd1);
    expect_msg("R8", 0);
    for (int v = 1; v < NV; v++) begin
      pulse(v);
      expect_msg("R8", v);
    end

    // R7 entry mask, R13 merge, R9 replay on unmask
    wr(16'h002C, 32'd1);
    pulse(2);
    expect_none("R7", 4);
    expect_pend("R7", 32'h04);
    pulse(2);
    wr(16'h002C, 32'd0);
    expect_msg("R9", 2);
    expect_none("R13", 6);
    expect_pend("R9", 32'd0);

    // R10 function mask-all, replay in ascending order under back-pressure
    ctl(8'hC0);
    chk("R5", 64'(intx_clr), 64'd1);
    pulse(5); pulse(0); pulse(3);
    expect_none("R7", 3);
    expect_pend("R7", 32'h29);
    msg_ready = 0;
    ctl(8'h80);
    for (int i = 0; i < 12 && !msg_valid; i++) tick();
    chk("R10", msg_addr, {exp_word(0, 1), exp_word(0, 0)});
    a0 = msg_addr;
    repeat (3) tick();
    chk("R10", 64'(msg_valid), 64'd1);
    chk("R10", msg_addr, a0);
    msg_ready = 1;
    tick();
    expect_msg("R10", 3);
    expect_msg("R10", 5);
    expect_none("R10", 4);
    expect_pend("R9", 32'd0);

    // R5 disabled function masks, re-enable replays
    ctl(8'h00);
    chk("R5", 64'(intx_clr), 64'd0);
    pulse(1);
    expect_none("R5", 4);
    expect_pend("R5", 32'h02);
    ctl(8'h80);
    expect_msg("R5", 1);

    // R11 use counts
    wr(16'h004C, 32'd1);
    pulse(4);
    expect_pend("R11", 32'h10);
    cnt(4, 1);
    cnt(4, 0);
    expect_pend("R11", 32'h10);
    cnt(4, 0);
    expect_pend("R11", 32'd0);
    wr(16'h004C, 32'd0);
    expect_none("R9", 6);
    cnt(4, 0);
    cnt(4, 1);
    pulse(4);
    expect_msg("R11", 4);
    for (int i = 0; i < 5; i++) cnt(5, 1);
    for (int i = 0; i < 3; i++) cnt(5, 0);
    pulse(5);
    expect_none("R11", 6);

    // R9 unmask with nothing pending
    wr(16'h000C, 32'd1);
    wr(16'h000C, 32'd0);
    expect_none("R9", 6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule